// File: doc/BRIEF.md
# CAN Receive Rule Filter

This block sits behind a CAN controller and decides what happens to each completed frame. The controller presents the frame's identifier, format bit (standard or extended), remote-request bit and data length code together with a one-cycle valid strobe. The block then walks a programmable table of receive rules, one rule per clock, starting at rule 0. The first rule that matches the frame decides the frame's fate. If it passes that rule's minimum-length test and the rule's destination queue has room, the frame's identifier, length code and the index of the rule that caught it are stored in that destination queue. If any step fails, the frame is discarded.

Rules are loaded through a simple write port. One write sets one rule: an enable bit, a reference identifier, a compare mask, the expected format and remote bits, a minimum length code and a destination queue number. Each destination queue is a small first-in first-out store that a consumer drains through a pop strobe, with full and empty flags and the head entry always visible.

The controller is a state machine with three states. In IDLE it waits for a frame. The IDLE to SCAN transition is taken on a frame strobe. SCAN to SCAN advances the rule index when the current rule does not match. SCAN to REPORT is taken on the first match, or after the last rule has been tried. REPORT to IDLE always follows after one cycle, and the outcome pulse is raised in that cycle. The busy output is high in SCAN and REPORT.

Top module: `can_rx_rule_filter`

## Requirements
- R1: After reset, busy and all four outcome pulses are low, every queue reports empty and not full, and every rule is disabled, so a frame produces the no-match outcome.
- R2: An enabled rule matches a frame when every identifier bit with a mask bit of 1 equals the rule's identifier bit (mask bit 0 means that bit is not compared), and both the format bit and the remote-request bit equal the rule's values.
- R3: Rules are tried in ascending index order, and only the lowest-numbered matching rule is used. The stored rule index names that rule.
- R4: The length test uses only the matched rule. It passes when the rule's minimum length code is 0 or when the frame's length code is greater than or equal to it. On failure, dlc_fail_pulse is raised, nothing is stored, and no higher rule is tried.
- R5: When no enabled rule matches, nomatch_pulse is raised and nothing is stored.
- R6: An accepted frame raises acc_pulse and is appended to the matched rule's destination queue as identifier, length code and rule index.
- R7: If the destination queue is full, full_drop_pulse is raised instead. The new frame is discarded and the stored entries stay unchanged.
- R8: busy rises on the clock edge that captures the frame strobe. When the match is at rule k, busy stays high for k+2 cycles. With no match it stays high for NUM_RULES+1 cycles. The outcome pulse occurs in the last busy cycle.
- R9: A frame strobe has no effect while busy is high.
- R10: Each queue holds FIFO_DEPTH entries and returns them in arrival order. A pop on an empty queue has no effect. Destination d's head appears at bits [d*ID_W +: ID_W] of q_id, [d*DLC_W +: DLC_W] of q_dlc and [d*IDX_W +: IDX_W] of q_rule.
- R11: Each frame produces exactly one of the four outcome pulses, each one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write one rule |
| cfg_idx | input | IDX_W | Rule index to write |
| cfg_en | input | 1 | Rule enable |
| cfg_id | input | ID_W | Rule reference identifier |
| cfg_mask | input | ID_W | Compare mask (1 = compare bit) |
| cfg_ide | input | 1 | Expected format bit |
| cfg_rtr | input | 1 | Expected remote-request bit |
| cfg_min_dlc | input | DLC_W | Minimum length code (0 = no test) |
| cfg_dest | input | DEST_W | Destination queue number |
| frm_valid | input | 1 | Frame strobe |
| frm_id | input | ID_W | Frame identifier, held while busy |
| frm_ide | input | 1 | Frame format bit |
| frm_rtr | input | 1 | Frame remote-request bit |
| frm_dlc | input | DLC_W | Frame length code |
| busy | output | 1 | Scan in progress |
| acc_pulse | output | 1 | Frame stored |
| nomatch_pulse | output | 1 | No rule matched |
| dlc_fail_pulse | output | 1 | Matched rule's length test failed |
| full_drop_pulse | output | 1 | Destination full, frame dropped |
| q_pop | input | NUM_DEST | Pop strobe per queue |
| q_full | output | NUM_DEST | Queue full flags |
| q_empty | output | NUM_DEST | Queue empty flags |
| q_id | output | NUM_DEST*ID_W | Head identifiers |
| q_dlc | output | NUM_DEST*DLC_W | Head length codes |
| q_rule | output | NUM_DEST*IDX_W | Head rule indices |

## Verification
The bench builds the block with its defaults: 16 rules, 29-bit identifiers, two destination queues of four entries each. With these values, a match on the very last rule (index 15) is reachable, which gives the longest accepting scan. A queue can be filled with four frames and then overflowed by a fifth. Overlapping rules at low and high indices show the first-match and no-retry behaviour on a short frame that a later rule would have taken.

// File: rtl/can_rxf_pkg.sv
package can_rxf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_REPORT = 2'd2
    } scan_state_e;

    typedef enum logic [1:0] {
        VERD_NONE  = 2'd0,
        VERD_HIT   = 2'd1,
        VERD_SHORT = 2'd2
    } verdict_e;

endpackage

// File: rtl/rxf_rule_table.sv
module rxf_rule_table #(
    parameter int NUM_RULES = 16,
    parameter int ID_W      = 29,
    parameter int DLC_W     = 4,
    parameter int DEST_W    = 1,
    parameter int IDX_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [ID_W-1:0]   wr_mask,
    input  logic              wr_ide,
    input  logic              wr_rtr,
    input  logic [DLC_W-1:0]  wr_min_dlc,
    input  logic [DEST_W-1:0] wr_dest,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [ID_W-1:0]   rd_id,
    output logic [ID_W-1:0]   rd_mask,
    output logic              rd_ide,
    output logic              rd_rtr,
    output logic [DLC_W-1:0]  rd_min_dlc,
    output logic [DEST_W-1:0] rd_dest
);

    logic              ent_valid [NUM_RULES];
    logic [ID_W-1:0]   ent_id    [NUM_RULES];
    logic [ID_W-1:0]   ent_mask  [NUM_RULES];
    logic              ent_ide   [NUM_RULES];
    logic              ent_rtr   [NUM_RULES];
    logic [DLC_W-1:0]  ent_dlc   [NUM_RULES];
    logic [DEST_W-1:0] ent_dest  [NUM_RULES];

    for (genvar r = 0; r < NUM_RULES; r++) begin : g_entry
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(r));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_valid[r] <= 1'b0;
                ent_id[r]    <= '0;
                ent_mask[r]  <= '0;
                ent_ide[r]   <= 1'b0;
                ent_rtr[r]   <= 1'b0;
                ent_dlc[r]   <= '0;
                ent_dest[r]  <= '0;
            end else if (sel) begin
                ent_valid[r] <= wr_valid;
                ent_id[r]    <= wr_id;
                ent_mask[r]  <= wr_mask;
                ent_ide[r]   <= wr_ide;
                ent_rtr[r]   <= wr_rtr;
                ent_dlc[r]   <= wr_min_dlc;
                ent_dest[r]  <= wr_dest;
            end
        end
    end

    always_comb begin
        rd_valid   = ent_valid[rd_idx];
        rd_id      = ent_id[rd_idx];
        rd_mask    = ent_mask[rd_idx];
        rd_ide     = ent_ide[rd_idx];
        rd_rtr     = ent_rtr[rd_idx];
        rd_min_dlc = ent_dlc[rd_idx];
        rd_dest    = ent_dest[rd_idx];
    end

endmodule

// File: rtl/rxf_dest_fifo.sv
module rxf_dest_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 37
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[e] <= '0;
            else if (do_push && (wr_ptr == PW'(e)))
                mem[e] <= din;
        end
    end

    // R10
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R10
    fifo_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);

endmodule

// File: rtl/rxf_scan_ctrl.sv
module rxf_scan_ctrl
    import can_rxf_pkg::*;
#(
    parameter int NUM_RULES = 16,
    parameter int NUM_DEST  = 2,
    parameter int ID_W      = 29,
    parameter int DLC_W     = 4,
    parameter int DEST_W    = 1,
    parameter int IDX_W     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frm_valid,
    input  logic [ID_W-1:0]     frm_id,
    input  logic                frm_ide,
    input  logic                frm_rtr,
    input  logic [DLC_W-1:0]    frm_dlc,
    output logic [IDX_W-1:0]    rule_idx,
    input  logic                rule_valid,
    input  logic [ID_W-1:0]     rule_id,
    input  logic [ID_W-1:0]     rule_mask,
    input  logic                rule_ide,
    input  logic                rule_rtr,
    input  logic [DLC_W-1:0]    rule_min_dlc,
    input  logic [DEST_W-1:0]   rule_dest,
    input  logic [NUM_DEST-1:0] dest_full,
    output logic [NUM_DEST-1:0] push,
    output logic [IDX_W-1:0]    push_rule,
    output logic                busy,
    output logic                acc_pulse,
    output logic                nomatch_pulse,
    output logic                dlc_fail_pulse,
    output logic                full_drop_pulse
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_RULES - 1);

    scan_state_e       state, state_n;
    verdict_e          verd, verd_n;
    logic [IDX_W-1:0]  idx, idx_n;
    logic [IDX_W-1:0]  hit_idx, hit_idx_n;
    logic [DEST_W-1:0] hit_dest, hit_dest_n;
    logic              match, dlc_ok, store_ok;

    assign rule_idx = idx;
    assign match    = rule_valid
                   && (((frm_id ^ rule_id) & rule_mask) == '0)
                   && (frm_ide == rule_ide)
                   && (frm_rtr == rule_rtr);
    assign dlc_ok   = (rule_min_dlc == '0) || (frm_dlc >= rule_min_dlc);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            verd     <= VERD_NONE;
            idx      <= '0;
            hit_idx  <= '0;
            hit_dest <= '0;
        end else begin
            state    <= state_n;
            verd     <= verd_n;
            idx      <= idx_n;
            hit_idx  <= hit_idx_n;
            hit_dest <= hit_dest_n;
        end
    end

    // transitions
    always_comb begin
        state_n    = state;
        verd_n     = verd;
        idx_n      = idx;
        hit_idx_n  = hit_idx;
        hit_dest_n = hit_dest;
        unique case (state)
            ST_IDLE: begin
                if (frm_valid) begin
                    state_n = ST_SCAN;
                    idx_n   = '0;
                end
            end
            ST_SCAN: begin
                if (match) begin
                    state_n    = ST_REPORT;
                    verd_n     = dlc_ok ? VERD_HIT : VERD_SHORT;
                    hit_idx_n  = idx;
                    hit_dest_n = rule_dest;
                end else if (idx == LAST_IDX) begin
                    state_n = ST_REPORT;
                    verd_n  = VERD_NONE;
                end else begin
                    idx_n = idx + 1'b1;
                end
            end
            ST_REPORT: state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy            = (state != ST_IDLE);
        acc_pulse       = 1'b0;
        nomatch_pulse   = 1'b0;
        dlc_fail_pulse  = 1'b0;
        full_drop_pulse = 1'b0;
        store_ok        = 1'b0;
        if (state == ST_REPORT) begin
            unique case (verd)
                VERD_HIT: begin
                    store_ok        = !dest_full[hit_dest];
                    acc_pulse       = store_ok;
                    full_drop_pulse = !store_ok;
                end
                VERD_SHORT: dlc_fail_pulse = 1'b1;
                default:    nomatch_pulse  = 1'b1;
            endcase
        end
    end

    for (genvar d = 0; d < NUM_DEST; d++) begin : g_push
        assign push[d] = store_ok && (hit_dest == DEST_W'(d));
    end
    assign push_rule = hit_idx;

    // R11
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_pulse, nomatch_pulse, dlc_fail_pulse, full_drop_pulse}));

    // R3
    scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && !match && idx != LAST_IDX)
        |=> (state == ST_SCAN && idx == $past(idx) + 1'b1));

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(frm_valid));

endmodule

// File: rtl/can_rx_rule_filter.sv
module can_rx_rule_filter #(
    parameter int NUM_RULES  = 16,
    parameter int NUM_DEST   = 2,
    parameter int FIFO_DEPTH = 4,
    parameter int ID_W       = 29,
    parameter int DLC_W      = 4,
    parameter int IDX_W      = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1,
    parameter int DEST_W     = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_wr,
    input  logic [IDX_W-1:0]          cfg_idx,
    input  logic                      cfg_en,
    input  logic [ID_W-1:0]           cfg_id,
    input  logic [ID_W-1:0]           cfg_mask,
    input  logic                      cfg_ide,
    input  logic                      cfg_rtr,
    input  logic [DLC_W-1:0]          cfg_min_dlc,
    input  logic [DEST_W-1:0]         cfg_dest,
    input  logic                      frm_valid,
    input  logic [ID_W-1:0]           frm_id,
    input  logic                      frm_ide,
    input  logic                      frm_rtr,
    input  logic [DLC_W-1:0]          frm_dlc,
    output logic                      busy,
    output logic                      acc_pulse,
    output logic                      nomatch_pulse,
    output logic                      dlc_fail_pulse,
    output logic                      full_drop_pulse,
    input  logic [NUM_DEST-1:0]       q_pop,
    output logic [NUM_DEST-1:0]       q_full,
    output logic [NUM_DEST-1:0]       q_empty,
    output logic [NUM_DEST*ID_W-1:0]  q_id,
    output logic [NUM_DEST*DLC_W-1:0] q_dlc,
    output logic [NUM_DEST*IDX_W-1:0] q_rule
);

    localparam int ENT_W = ID_W + DLC_W + IDX_W;

    logic [IDX_W-1:0]    rule_idx;
    logic                rule_valid, rule_ide, rule_rtr;
    logic [ID_W-1:0]     rule_id, rule_mask;
    logic [DLC_W-1:0]    rule_min_dlc;
    logic [DEST_W-1:0]   rule_dest;
    logic [NUM_DEST-1:0] push;
    logic [IDX_W-1:0]    push_rule;
    logic [ENT_W-1:0]    push_data;

    assign push_data = {frm_id, frm_dlc, push_rule};

    rxf_rule_table #(
        .NUM_RULES(NUM_RULES), .ID_W(ID_W), .DLC_W(DLC_W),
        .DEST_W(DEST_W), .IDX_W(IDX_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr), .wr_idx(cfg_idx), .wr_valid(cfg_en),
        .wr_id(cfg_id), .wr_mask(cfg_mask), .wr_ide(cfg_ide),
        .wr_rtr(cfg_rtr), .wr_min_dlc(cfg_min_dlc), .wr_dest(cfg_dest),
        .rd_idx(rule_idx), .rd_valid(rule_valid), .rd_id(rule_id),
        .rd_mask(rule_mask), .rd_ide(rule_ide), .rd_rtr(rule_rtr),
        .rd_min_dlc(rule_min_dlc), .rd_dest(rule_dest)
    );

    rxf_scan_ctrl #(
        .NUM_RULES(NUM_RULES), .NUM_DEST(NUM_DEST), .ID_W(ID_W),
        .DLC_W(DLC_W), .DEST_W(DEST_W), .IDX_W(IDX_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .frm_valid(frm_valid), .frm_id(frm_id), .frm_ide(frm_ide),
        .frm_rtr(frm_rtr), .frm_dlc(frm_dlc),
        .rule_idx(rule_idx), .rule_valid(rule_valid), .rule_id(rule_id),
        .rule_mask(rule_mask), .rule_ide(rule_ide), .rule_rtr(rule_rtr),
        .rule_min_dlc(rule_min_dlc), .rule_dest(rule_dest),
        .dest_full(q_full), .push(push), .push_rule(push_rule),
        .busy(busy), .acc_pulse(acc_pulse), .nomatch_pulse(nomatch_pulse),
        .dlc_fail_pulse(dlc_fail_pulse), .full_drop_pulse(full_drop_pulse)
    );

    for (genvar d = 0; d < NUM_DEST; d++) begin : g_dest
        logic [ENT_W-1:0] head;

        rxf_dest_fifo #(.DEPTH(FIFO_DEPTH), .W(ENT_W)) u_fifo (
            .clk(clk), .rst_n(rst_n),
            .push(push[d]), .din(push_data), .pop(q_pop[d]),
            .dout(head), .full(q_full[d]), .empty(q_empty[d])
        );

        assign q_id[d*ID_W +: ID_W]     = head[ENT_W-1 -: ID_W];
        assign q_dlc[d*DLC_W +: DLC_W]  = head[IDX_W +: DLC_W];
        assign q_rule[d*IDX_W +: IDX_W] = head[IDX_W-1:0];
    end

    // R6
    acc_stores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_pulse |=> !(&q_empty));

endmodule

// File: tb/can_rx_rule_filter_bench.sv
module can_rx_rule_filter_bench;

    localparam int NR = 16, ND = 2, ID_W = 29, DLC_W = 4, IDX_W = 4, DEST_W = 1;
    localparam int OC_ACC = 0, OC_NOMATCH = 1, OC_DLC = 2, OC_FULL = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 0, cfg_en = 0, cfg_ide = 0, cfg_rtr = 0;
    logic [IDX_W-1:0] cfg_idx = '0;
    logic [ID_W-1:0] cfg_id = '0, cfg_mask = '0;
    logic [DLC_W-1:0] cfg_min_dlc = '0;
    logic [DEST_W-1:0] cfg_dest = '0;
    logic frm_valid = 0, frm_ide = 0, frm_rtr = 0;
    logic [ID_W-1:0] frm_id = '0;
    logic [DLC_W-1:0] frm_dlc = '0;
    logic busy, acc_pulse, nomatch_pulse, dlc_fail_pulse, full_drop_pulse;
    logic [ND-1:0] q_pop = '0, q_full, q_empty;
    logic [ND*ID_W-1:0] q_id;
    logic [ND*DLC_W-1:0] q_dlc;
    logic [ND*IDX_W-1:0] q_rule;

    int compared = 0, mismatched = 0;
    logic [ID_W+DLC_W+IDX_W-1:0] model [ND][$];

    always #2.5 clk = ~clk;

    can_rx_rule_filter u_can_rx_rule_filter (.*);

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    task automatic check(input string tag, input longint act, input longint exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic write_rule(input int i, input logic en, input logic [ID_W-1:0] id,
                              input logic [ID_W-1:0] mask, input logic ide, input logic rtr,
                              input int mdlc, input int dest);
        @(negedge clk);
        cfg_wr = 1; cfg_idx = IDX_W'(i); cfg_en = en; cfg_id = id; cfg_mask = mask;
        cfg_ide = ide; cfg_rtr = rtr; cfg_min_dlc = DLC_W'(mdlc); cfg_dest = DEST_W'(dest);
        @(negedge clk);
        cfg_wr = 0;
    endtask

    // Sends one frame, counts busy cycles and outcome pulses, updates the model.
    task automatic send_frame(input string tag, input logic [ID_W-1:0] id, input logic ide,
                              input logic rtr, input int dlc, input int strobe_len,
                              input int exp_oc, input int exp_busy,
                              input int exp_dest, input int exp_rule);
        int cyc = 0;
        int pulses = 0;
        int oc = -1;
        int last_pulse_cyc = -1;
        @(negedge clk);
        frm_id = id; frm_ide = ide; frm_rtr = rtr; frm_dlc = DLC_W'(dlc); frm_valid = 1;
        for (int s = 0; s < strobe_len; s++) begin
            @(negedge clk);
            if (s == strobe_len - 1) frm_valid = 0;
            if (busy) begin
                cyc++;
                if (acc_pulse)       begin pulses++; oc = OC_ACC;     last_pulse_cyc = cyc; end
                if (nomatch_pulse)   begin pulses++; oc = OC_NOMATCH; last_pulse_cyc = cyc; end
                if (dlc_fail_pulse)  begin pulses++; oc = OC_DLC;     last_pulse_cyc = cyc; end
                if (full_drop_pulse) begin pulses++; oc = OC_FULL;    last_pulse_cyc = cyc; end
            end
        end
        while (busy && cyc < 100) begin
            @(negedge clk);
            if (busy) begin
                cyc++;
                if (acc_pulse)       begin pulses++; oc = OC_ACC;     last_pulse_cyc = cyc; end
                if (nomatch_pulse)   begin pulses++; oc = OC_NOMATCH; last_pulse_cyc = cyc; end
                if (dlc_fail_pulse)  begin pulses++; oc = OC_DLC;     last_pulse_cyc = cyc; end
                if (full_drop_pulse) begin pulses++; oc = OC_FULL;    last_pulse_cyc = cyc; end
            end
        end
        check({tag, " R11 pulse count"}, pulses, 1);
        check({tag, " outcome"}, oc, exp_oc);
        check({tag, " R8 busy cycles"}, cyc, exp_busy);
        check({tag, " R8 pulse in last busy cycle"}, last_pulse_cyc, exp_busy);
        if (exp_oc == OC_ACC)
            model[exp_dest].push_back({id, DLC_W'(dlc), IDX_W'(exp_rule)});
    endtask

    task automatic check_queues(input string tag);
        for (int d = 0; d < ND; d++) begin
            check({tag, " R10 empty flag"}, q_empty[d], model[d].size() == 0);
            check({tag, " R10 full flag"}, q_full[d], model[d].size() == 4);
            if (model[d].size() != 0)
                check({tag, " R6 head entry"},
                      {q_id[d*ID_W +: ID_W], q_dlc[d*DLC_W +: DLC_W], q_rule[d*IDX_W +: IDX_W]},
                      model[d][0]);
        end
    endtask

    task automatic pop_queue(input string tag, input int d);
        @(negedge clk);
        q_pop[d] = 1'b1;
        @(negedge clk);
        q_pop[d] = 1'b0;
        if (model[d].size() != 0) void'(model[d].pop_front());
        check_queues(tag);
    endtask

    task automatic t_reset();
        check("R1 busy after reset", busy, 0);
        check("R1 pulses after reset",
              {acc_pulse, nomatch_pulse, dlc_fail_pulse, full_drop_pulse}, 0);
        check_queues("R1 reset");
        send_frame("R1 empty table", 29'h0, 0, 0, 0, 1, OC_NOMATCH, NR + 1, 0, 0);
    endtask

    task automatic t_load_rules();
        write_rule(2,  1, 29'h123,     29'h1FFF_FFFF, 0, 0, 4, 0);
        write_rule(5,  1, 29'h120,     29'h1FFF_FFF0, 0, 0, 0, 1);
        write_rule(7,  1, 29'h300,     29'h1FFF_FFFF, 0, 1, 0, 0);
        write_rule(15, 1, 29'h0ABCDEF, 29'h1FFF_FFFF, 1, 0, 0, 1);
    endtask

    task automatic t_match_and_order();
        send_frame("R3 lowest rule wins", 29'h123, 0, 0, 8, 1, OC_ACC, 4, 0, 2);
        check_queues("R6 after first accept");
        send_frame("R2 masked bits ignored", 29'h12A, 0, 0, 1, 1, OC_ACC, 7, 1, 5);
        send_frame("R2 format bit differs", 29'h123, 1, 0, 8, 1, OC_NOMATCH, NR + 1, 0, 0);
        send_frame("R2 remote bit matches", 29'h300, 0, 1, 0, 1, OC_ACC, 9, 0, 7);
        send_frame("R5 remote bit differs", 29'h300, 0, 0, 0, 1, OC_NOMATCH, NR + 1, 0, 0);
        send_frame("R8 last rule hit", 29'h0ABCDEF, 1, 0, 3, 1, OC_ACC, NR + 1, 1, 15);
        check_queues("R6 after mixed frames");
    endtask

    task automatic t_dlc();
        send_frame("R4 short frame no retry", 29'h123, 0, 0, 2, 1, OC_DLC, 4, 0, 0);
        check_queues("R4 nothing stored");
        send_frame("R4 equal length passes", 29'h123, 0, 0, 4, 1, OC_ACC, 4, 0, 2);
    endtask

    task automatic t_busy_ignore();
        send_frame("R9 strobe held while busy", 29'h0ABCDEF, 1, 0, 5, 6, OC_ACC, NR + 1, 1, 15);
        check_queues("R9 single store");
    endtask

    task automatic t_full();
        send_frame("R7 fill fourth", 29'h123, 0, 0, 9, 1, OC_ACC, 4, 0, 2);
        check_queues("R10 queue full");
        send_frame("R7 drop on full", 29'h123, 0, 0, 15, 1, OC_FULL, 4, 0, 2);
        check_queues("R7 contents unchanged");
        for (int k = 0; k < 4; k++) pop_queue("R10 drain order", 0);
    endtask

    task automatic t_pop_empty();
        for (int k = 0; k < 3; k++) pop_queue("R10 drain q1", 1);
        pop_queue("R10 pop on empty", 1);
        send_frame("R10 push after empty pop", 29'h125, 0, 0, 6, 1, OC_ACC, 7, 1, 5);
        check_queues("R10 head after refill");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_rules();
        t_match_and_order();
        t_dlc();
        t_busy_ignore();
        t_full();
        t_pop_empty();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule